// File: doc/BRIEF.md
# H-Bridge Gate Sequencer

This block is the synchronous control core for a full bridge built from two half-bridge legs. Each leg takes a low-switch command and a high-switch command and drives two gate-enable outputs. The block itself keeps a leg from ever conducting on both switches, so the commands arriving from a pulse-width modulator or a control loop can be used as they come. A shared disable, a shared supply-undervoltage flag and a per-leg high-rail undervoltage flag can force gates off. A single dead-time setting, counted in clock cycles, applies to every leg.

A gate turns off with a fixed pipeline latency and no added wait. A gate turns on only after its request has been steady for the dead time, counted from the moment the opposite gate of its leg is off. The low command has priority inside a leg, so holding the high command at 1 makes the low command alone steer the leg between its two switches. When disable or supply undervoltage is released, the low gates may turn on again at once, while the high gates stay blocked for a fixed refresh window. This lets the lower switches recharge the high-side bootstrap supplies first. All commands and flags pass through two-flop synchronisers. The outputs are plain level signals with no handshake.

Top module: `hbridge_gate_ctl`

## Requirements
- R1: In every cycle, the low and high gate outputs of one leg are never both 1.
- R2: Disable at 1 forces all four gate outputs to 0 regardless of the other inputs. The outputs are 0 from the third rising edge after the input change.
- R3: In a leg, a low command of 1 turns the high gate off and turns the low gate on, whatever the high command is. From an all-off leg the low gate rises at edge 3+D after the change, where D is the dead-time setting.
- R4: In a leg, low command 0 with high command 1 turns the high gate on, at edge 3+D from an all-off leg. Both commands at 0 turn both gates off.
- R5: With the high command held at 1, toggling the low command moves the leg between its two switches. The newly selected gate rises at edge 4+D, because the gate being released first falls at edge 3.
- R6: A gate whose request goes away falls at edge 3 with no dead-time wait.
- R7: The supply undervoltage flag at 1 forces all four gates to 0 from edge 3.
- R8: The high-rail undervoltage flag of a leg forces only that leg's high gate to 0 from edge 3. After the flag is released, the high gate returns at edge 3+D, with no refresh window.
- R9: After disable or supply undervoltage is released, a low gate rises at edge 3+D. A high gate stays off until edge 3+H+D, where H is the refresh window (parameter REFRESH_CYC).
- R10: A command pulse of L cycles gives an output pulse of L-D cycles when L > D, and no output pulse otherwise. An interrupted turn-on restarts its dead-time count.
- R11: During and right after reset, all gate outputs are 0.
- R12: The two legs are independent. Activity on one leg does not disturb a steady gate on the other leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dis_i | input | 1 | Disable; 1 forces all gates off |
| uv_supply_i | input | 1 | Supply undervoltage flag; 1 forces all gates off |
| uv_hi_i | input | LEGS | Per-leg high-rail undervoltage flag (bit 0 = leg A, bit 1 = leg B) |
| cmd_lo_i | input | LEGS | Per-leg low-switch command |
| cmd_hi_i | input | LEGS | Per-leg high-switch command |
| dead_cyc_i | input | DT_W | Dead time D in clock cycles (quasi-static) |
| gate_lo_o | output | LEGS | Low-switch gate enables |
| gate_hi_o | output | LEGS | High-switch gate enables |

## Verification
The dead time is swept over several values on both legs. At each value the bench drives turn-on from an all-off leg, a handover between switches with the high command held, a low command overriding a held high command, and plain turn-offs. This separates the 3+D path from the 4+D path and shows that turn-off has a fixed latency. Pulses of exactly D and D+1 cycles check that the dead-time count restarts and sets the minimum width. Disable, supply undervoltage and per-leg high-rail undervoltage are each applied with one leg on its high switch and the other on its low switch. This shows which gates each flag clears, and whether the refresh window delays only the high gates on release.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  localparam int SYNC_STAGES = 2;
  typedef struct packed {
    logic lo;
    logic hi;
  } leg_req_t;
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/hbg_gate_timer.sv
module hbg_gate_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            peer_on_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            on_o
);
  logic [DT_W-1:0] wait_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_o   <= 1'b0;
      wait_q <= '0;
    end else if (!req_i) begin
      // turn-off is immediate and the count restarts
      on_o   <= 1'b0;
      wait_q <= '0;
    end else if (!on_o) begin
      if (peer_on_i) begin
        wait_q <= '0;
      end else if (wait_q >= dead_i) begin
        on_o <= 1'b1;
      end else begin
        wait_q <= wait_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hbg_release.sv
module hbg_release #(
  parameter int REFRESH_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill_i,
  output logic hi_ok_o
);
  localparam int CW = $clog2(REFRESH_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(REFRESH_CYC);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (kill_i)         cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end
  assign hi_ok_o = (cnt_q == LIMIT);
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg
  import hbg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_lo_i,
  input  logic            s_hi_i,
  input  logic            s_uvh_i,
  input  logic            kill_i,
  input  logic            hi_ok_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            gate_lo_o,
  output logic            gate_hi_o
);
  leg_req_t req;
  always_comb begin
    req.lo = s_lo_i & ~kill_i;
    req.hi = s_hi_i & ~s_lo_i & ~kill_i & ~s_uvh_i & hi_ok_i;
  end

  hbg_gate_timer #(.DT_W(DT_W)) u_lo (
    .clk(clk), .rst_n(rst_n), .req_i(req.lo), .peer_on_i(gate_hi_o),
    .dead_i(dead_i), .on_o(gate_lo_o)
  );
  hbg_gate_timer #(.DT_W(DT_W)) u_hi (
    .clk(clk), .rst_n(rst_n), .req_i(req.hi), .peer_on_i(gate_lo_o),
    .dead_i(dead_i), .on_o(gate_hi_o)
  );
endmodule

// File: rtl/hbridge_gate_ctl.sv
module hbridge_gate_ctl #(
  parameter int LEGS        = 2,
  parameter int DT_W        = 8,
  parameter int REFRESH_CYC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dis_i,
  input  logic            uv_supply_i,
  input  logic [LEGS-1:0] uv_hi_i,
  input  logic [LEGS-1:0] cmd_lo_i,
  input  logic [LEGS-1:0] cmd_hi_i,
  input  logic [DT_W-1:0] dead_cyc_i,
  output logic [LEGS-1:0] gate_lo_o,
  output logic [LEGS-1:0] gate_hi_o
);
  localparam int SW = 3 * LEGS + 2;

  logic [SW-1:0] raw, synced;
  logic [LEGS-1:0] s_lo, s_hi, s_uvh;
  logic s_dis, s_uv, kill, hi_ok;

  assign raw = {dis_i, uv_supply_i, uv_hi_i, cmd_hi_i, cmd_lo_i};

  hbg_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  assign {s_dis, s_uv, s_uvh, s_hi, s_lo} = synced;
  assign kill = s_dis | s_uv;

  hbg_release #(.REFRESH_CYC(REFRESH_CYC)) u_rel (
    .clk(clk), .rst_n(rst_n), .kill_i(kill), .hi_ok_o(hi_ok)
  );

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    hbg_leg #(.DT_W(DT_W)) u_leg (
      .clk(clk), .rst_n(rst_n),
      .s_lo_i(s_lo[g]), .s_hi_i(s_hi[g]), .s_uvh_i(s_uvh[g]),
      .kill_i(kill), .hi_ok_i(hi_ok), .dead_i(dead_cyc_i),
      .gate_lo_o(gate_lo_o[g]), .gate_hi_o(gate_hi_o[g])
    );
  end
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int LEGS = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dis_i,
  input logic            uv_supply_i,
  input logic [LEGS-1:0] uv_hi_i,
  input logic [LEGS-1:0] cmd_lo_i,
  input logic [LEGS-1:0] gate_lo_o,
  input logic [LEGS-1:0] gate_hi_o
);
  a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis_i, 3) |-> (gate_lo_o == '0 && gate_hi_o == '0));

  a_r7_supply_uv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uv_supply_i, 3) |-> (gate_lo_o == '0 && gate_hi_o == '0));

  for (genvar g = 0; g < LEGS; g++) begin : g_chk
    a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_lo_o[g] && gate_hi_o[g]));

    a_r3_low_priority: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_lo_i[g], 3) |-> !gate_hi_o[g]);

    a_r8_rail_uv: assert property (@(posedge clk) disable iff (!rst_n)
      $past(uv_hi_i[g], 3) |-> !gate_hi_o[g]);

    a_r5_lo_after_hi_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_lo_o[g]) |-> $past(!gate_hi_o[g]));

    a_r5_hi_after_lo_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi_o[g]) |-> $past(!gate_lo_o[g]));
  end
endmodule

bind hbridge_gate_ctl hbg_checker #(.LEGS(LEGS)) u_hbg_checker (
  .clk(clk), .rst_n(rst_n), .dis_i(dis_i), .uv_supply_i(uv_supply_i),
  .uv_hi_i(uv_hi_i), .cmd_lo_i(cmd_lo_i),
  .gate_lo_o(gate_lo_o), .gate_hi_o(gate_hi_o)
);

// File: tb/hbridge_gate_ctl_test.sv
module hbridge_gate_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DT_W = 4;
  localparam int HOLD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dis = 1'b0, uvs = 1'b0;
  logic [1:0] uvh = '0, clo = '0, chi = '0;
  logic [DT_W-1:0] dead = '0;
  logic [1:0] glo, ghi;

  int checks = 0, errors = 0, shoot = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_gate_ctl #(.LEGS(2), .DT_W(DT_W), .REFRESH_CYC(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .dis_i(dis), .uv_supply_i(uvs), .uv_hi_i(uvh),
    .cmd_lo_i(clo), .cmd_hi_i(chi), .dead_cyc_i(dead),
    .gate_lo_o(glo), .gate_hi_o(ghi)
  );

  always @(negedge clk)
    if (rst_n) for (int h = 0; h < 2; h++) if (glo[h] && ghi[h]) shoot++;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit outbit(int sel);
    return sel[0] ? ghi[sel/2] : glo[sel/2];
  endfunction

  // counts negedges from the drive until the chosen output reaches val
  task automatic wait_for(int sel, bit val, int exp_n, string req);
    int n = 0;
    while (outbit(sel) !== val && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(n == exp_n, req, n, exp_n);
  endtask

  task automatic go_idle();
    clo = '0; chi = '0; uvh = '0; dis = 1'b0; uvs = 1'b0;
    repeat (HOLD + 12) @(negedge clk);
  endtask

  task automatic pulse(int h, int len, int d);
    int cnt = 0;
    clo[h] = 1'b1;
    for (int i = 0; i < len; i++) begin @(negedge clk); cnt += glo[h]; end
    clo[h] = 1'b0;
    for (int i = 0; i < d + 8; i++) begin @(negedge clk); cnt += glo[h]; end
    check(cnt == ((len > d) ? len - d : 0), "R10 pulse width", cnt,
          (len > d) ? len - d : 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int dl[4] = '{0, 1, 3, 6};
    int lo_sel, hi_sel;
    bit kept;
    repeat (3) @(negedge clk);
    check(glo == 2'b00 && ghi == 2'b00, "R11 in reset", {glo, ghi}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(glo == 2'b00 && ghi == 2'b00, "R11 after reset", {glo, ghi}, 0);
    go_idle();

    foreach (dl[k]) begin
      dead = DT_W'(dl[k]);
      for (int h = 0; h < 2; h++) begin
        lo_sel = 2 * h; hi_sel = 2 * h + 1;
        go_idle();
        // R3: low from idle, then held high command is overridden
        clo[h] = 1'b1;
        wait_for(lo_sel, 1'b1, 3 + dl[k], "R3 low on");
        chi[h] = 1'b1;
        repeat (8) @(negedge clk);
        check(ghi[h] == 1'b0, "R3 high blocked", ghi[h], 0);
        // R5: handover to high
        clo[h] = 1'b0;
        wait_for(hi_sel, 1'b1, 4 + dl[k], "R5 hand to high");
        clo[h] = 1'b1;
        wait_for(lo_sel, 1'b1, 4 + dl[k], "R5 hand to low");
        // R6: turn-off of low
        clo[h] = 1'b0; chi[h] = 1'b0;
        wait_for(lo_sel, 1'b0, 3, "R6 low off");
        go_idle();
        // R4: high from idle and turn-off
        chi[h] = 1'b1;
        wait_for(hi_sel, 1'b1, 3 + dl[k], "R4 high on");
        chi[h] = 1'b0;
        wait_for(hi_sel, 1'b0, 3, "R6 high off");
        repeat (4) @(negedge clk);
        check(glo[h] == 0 && ghi[h] == 0, "R4 both off", {glo[h], ghi[h]}, 0);
        // R10: minimum pulse
        go_idle();
        pulse(h, dl[k] + 1, dl[k]);
        if (dl[k] > 0) pulse(h, dl[k], dl[k]);
        pulse(h, dl[k] + 3, dl[k]);
      end
    end

    // R12: leg B steady low while leg A toggles
    dead = 4'd2;
    go_idle();
    clo[1] = 1'b1;
    repeat (10) @(negedge clk);
    kept = 1'b1;
    chi[0] = 1'b1;
    for (int i = 0; i < 6; i++) begin
      clo[0] = ~clo[0];
      repeat (9) begin @(negedge clk); kept &= glo[1]; end
    end
    check(kept, "R12 leg B undisturbed", kept, 1);

    // R2 and R9: disable with leg A high, leg B low
    go_idle();
    chi[0] = 1'b1; clo[1] = 1'b1;
    repeat (12) @(negedge clk);
    dis = 1'b1;
    wait_for(1, 1'b0, 3, "R2 disable high A");
    check(glo[1] == 1'b0, "R2 disable low B", glo[1], 0);
    chi[1] = 1'b1;
    repeat (6) @(negedge clk);
    check(glo == 0 && ghi == 0, "R2 disable holds", {glo, ghi}, 0);
    chi[1] = 1'b0;
    repeat (6) @(negedge clk);
    dis = 1'b0;
    wait_for(2, 1'b1, 5, "R9 low first");
    wait_for(1, 1'b1, HOLD, "R9 high after refresh");

    // R7: supply undervoltage
    uvs = 1'b1;
    wait_for(2, 1'b0, 3, "R7 uv low B");
    check(ghi[0] == 1'b0, "R7 uv high A", ghi[0], 0);
    repeat (5) @(negedge clk);
    uvs = 1'b0;
    wait_for(2, 1'b1, 5, "R9 uv release low");
    wait_for(1, 1'b1, HOLD, "R9 uv release high");

    // R8: rail undervoltage on leg A only
    uvh[0] = 1'b1;
    wait_for(1, 1'b0, 3, "R8 rail uv high A");
    repeat (5) @(negedge clk);
    check(glo[1] == 1'b1, "R8 leg B kept", glo[1], 1);
    uvh[0] = 1'b0;
    wait_for(1, 1'b1, 5, "R8 rail uv release");

    check(shoot == 0, "R1 no overlap", shoot, 0);
    finish_run();
  end
endmodule